// File: doc/BRIEF.md
# SPI Channel FIFO and Interrupt Register File

This block is the software-visible register side of one SPI channel. A host writes and reads 32-bit registers through a single-cycle strobe interface: configuration, clock divider, command, status, interrupt enable, FIFO thresholds, a packed FIFO occupancy word, a transmit-data port and a receive-data port. Behind the data ports sit an eight-word transmit FIFO and an eight-word receive FIFO.

The serial engine sits on the other side. It pulls transmit words through a valid/ready handshake, pushes received words with a valid pulse, and reports completion and transmit underflow as single-cycle pulses. Those pulses, together with the FIFO threshold crossings and receive overflow, are latched in a write-one-to-clear status register. A level interrupt is raised while any latched event has its enable bit set.

Read data is combinational from the address in the same cycle as the read strobe. A read of the receive-data port pops the receive FIFO at that clock edge.

Top module: `spi_chan_regs`

## Requirements
- R1: After reset, every register reads zero, except the divider, which reads 4. The word count reads 0 and `irq_o` is low.
- R2: Offsets are 0x00 configuration (32 bits), 0x04 divider (low 16 bits kept), 0x08 command (32 bits), 0x0C status, 0x10 interrupt enable (low 5 bits kept) and 0x14 threshold (low 8 bits kept). Each reads back what was written within its width. A read of 0x1C transmit data returns 0.
- R3: Writes to 0x1C enter an eight-word transmit FIFO. The FIFO's occupancy appears in bits [7:4] of 0x18. A write while the FIFO holds eight words is dropped.
- R4: Engine words enter an eight-word receive FIFO. Its occupancy appears in bits [3:0] of 0x18. A word that arrives while the FIFO is full is dropped and sets status bit 5 (receive overflow).
- R5: A read of 0x20 returns the receive words in arrival order. While the FIFO is empty the read returns 0 and leaves the occupancy unchanged.
- R6: Status bit 0 (pending) is set by a write to the command register and cleared by the engine's done pulse. Bit 1 (done) is set by the done pulse. Bit 4 (transmit underflow) is set by the engine's underflow pulse.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R8: Threshold bits [3:0] are the receive level and bits [7:4] the transmit level. Status bit 3 sets when receive occupancy rises to at least its level. Status bit 2 sets when transmit occupancy falls to at or below its level.
- R9: `irq_o` is the OR of the following pairs: enable bit 0 with status bit 1, enable bit 1 with status bit 2, enable bit 2 with status bit 3, enable bit 3 with status bit 4, and enable bit 4 with status bit 5. With enable 0 it stays low.
- R10: `tx_valid_o` is high exactly while the transmit FIFO is non-empty. `tx_word_o` shows the oldest word, which is removed at each edge where `tx_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| cfg_o | output | 32 | Configuration register to the engine |
| div_o | output | 16 | Divider register to the engine |
| cmd_o | output | 32 | Command register to the engine |
| cmd_start_o | output | 1 | Pulse on each command write |
| tx_word_o | output | 32 | Head of transmit FIFO |
| tx_valid_o | output | 1 | Transmit FIFO non-empty |
| tx_ready_i | input | 1 | Engine takes the head word |
| rx_word_i | input | 32 | Received word from engine |
| rx_valid_i | input | 1 | Received word valid, one per cycle |
| xfer_done_i | input | 1 | Transfer complete pulse |
| tx_uflow_i | input | 1 | Transmit underflow pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench fills the transmit FIFO with one word too many. A design that accepted the ninth write would report a count of 9, or would overwrite the head word. It overruns the receive FIFO in the same way and expects the overflow bit. It then reads the empty receive port, where a broken pointer guard would return stale data or wrap the count. For status, it clears a bit in the same cycle the event recurs, so a clear-wins design would lose the bit. It also moves the occupancy across both threshold levels in the direction that should fire, catching comparisons that are inverted or off by one. Finally it walks the enable-to-status mapping, where a shifted mapping would raise or miss the interrupt.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  localparam int ADDR_W = 8;
  localparam int STAT_W = 6;
  localparam int IEN_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_THR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h20;

  localparam int SB_PEND = 0;
  localparam int SB_DONE = 1;
  localparam int SB_TXTH = 2;
  localparam int SB_RXTH = 3;
  localparam int SB_TXUF = 4;
  localparam int SB_RXOF = 5;

  // enable bit k guards status bit k+1
  function automatic logic irq_calc(logic [STAT_W-1:0] st, logic [IEN_W-1:0] en);
    return |(st[STAT_W-1:1] & en);
  endfunction

  function automatic logic [31:0] pack_counts(logic [3:0] txc, logic [3:0] rxc);
    return {24'd0, txc, rxc};
  endfunction

  function automatic logic rx_level_hit(logic [3:0] occ, logic [3:0] lvl);
    return occ >= lvl;
  endfunction

  function automatic logic tx_level_hit(logic [3:0] occ, logic [3:0] lvl);
    return occ <= lvl;
  endfunction
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [W-1:0]                 pdata_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem[rp];
  assign count_o = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= pdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (cnt == CW'(DEPTH)));
  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (cnt == '0));
endmodule

// File: rtl/spi_evt_status.sv
module spi_evt_status
  import spi_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= (stat_o & ~clr_i) | set_i;
  end

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & $past(clr_i & ~set_i)) == '0));
  // R6
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
  import spi_chan_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_start_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  input  logic              xfer_done_i,
  input  logic              tx_uflow_i,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic [IEN_W-1:0]  ien_q;
  logic [7:0]        thr_q;
  logic [STAT_W-1:0] stat, st_set, st_clr;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic              wr_txd, rd_rxd, wr_stat;
  logic              rx_cond, tx_cond, rx_cond_q, tx_cond_q;
  logic              rx_th_evt, tx_th_evt, rx_of_evt;

  assign wr_txd      = bus_wr_i && (bus_addr_i == OFS_TXD);
  assign rd_rxd      = bus_rd_i && (bus_addr_i == OFS_RXD);
  assign wr_stat     = bus_wr_i && (bus_addr_i == OFS_STAT);
  assign cmd_start_o = bus_wr_i && (bus_addr_i == OFS_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= '0;
      div_o <= DIV_W'(DIV_RST);
      cmd_o <= '0;
      ien_q <= '0;
      thr_q <= '0;
    end else if (bus_wr_i) begin
      case (bus_addr_i)
        OFS_CFG: cfg_o <= bus_wdata_i;
        OFS_DIV: div_o <= bus_wdata_i[DIV_W-1:0];
        OFS_CMD: cmd_o <= bus_wdata_i;
        OFS_IEN: ien_q <= bus_wdata_i[IEN_W-1:0];
        OFS_THR: thr_q <= bus_wdata_i[7:0];
        default: ;
      endcase
    end
  end

  spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(wr_txd), .pdata_i(bus_wdata_i),
    .pop_i(tx_ready_i), .head_o(tx_word_o),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_valid_i), .pdata_i(rx_word_i),
    .pop_i(rd_rxd), .head_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign tx_valid_o = !tx_empty;

  // threshold events fire on the crossing, not on the level
  assign rx_cond = rx_level_hit(4'(rx_cnt), thr_q[3:0]);
  assign tx_cond = tx_level_hit(4'(tx_cnt), thr_q[7:4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cond_q <= 1'b1;
      tx_cond_q <= 1'b1;
    end else begin
      rx_cond_q <= rx_cond;
      tx_cond_q <= tx_cond;
    end
  end

  assign rx_th_evt = rx_cond && !rx_cond_q;
  assign tx_th_evt = tx_cond && !tx_cond_q;
  assign rx_of_evt = rx_valid_i && rx_full;

  always_comb begin
    st_set          = '0;
    st_set[SB_PEND] = cmd_start_o;
    st_set[SB_DONE] = xfer_done_i;
    st_set[SB_TXTH] = tx_th_evt;
    st_set[SB_RXTH] = rx_th_evt;
    st_set[SB_TXUF] = tx_uflow_i;
    st_set[SB_RXOF] = rx_of_evt;
    st_clr          = wr_stat ? bus_wdata_i[STAT_W-1:0] : '0;
    st_clr[SB_PEND] = st_clr[SB_PEND] | xfer_done_i;
  end

  spi_evt_status stat_i (
    .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(st_clr), .stat_o(stat)
  );

  assign irq_o = irq_calc(stat, ien_q);

  always_comb begin
    case (bus_addr_i)
      OFS_CFG:  bus_rdata_o = cfg_o;
      OFS_DIV:  bus_rdata_o = DATA_W'(div_o);
      OFS_CMD:  bus_rdata_o = cmd_o;
      OFS_STAT: bus_rdata_o = DATA_W'(stat);
      OFS_IEN:  bus_rdata_o = DATA_W'(ien_q);
      OFS_THR:  bus_rdata_o = DATA_W'(thr_q);
      OFS_CNT:  bus_rdata_o = DATA_W'(pack_counts(4'(tx_cnt), 4'(rx_cnt)));
      OFS_RXD:  bus_rdata_o = rx_head;
      default:  bus_rdata_o = '0;
    endcase
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_o);
  // R4
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_full) |=> stat[SB_RXOF]);
  // R10
  tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && (tx_cnt == CW'(1)) && !wr_txd) |=> !tx_valid_o);
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_i && !cmd_start_o) |=> !stat[SB_PEND]);
endmodule

// File: tb/spi_chan_regs_tb.sv
module spi_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] cfg, cmd, tx_word, rx_word = 0;
  logic [15:0] div;
  logic        cmd_start, tx_valid, tx_ready = 0, rx_valid = 0;
  logic        xfer_done = 0, tx_uflow = 0, irq;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  spi_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cfg_o(cfg), .div_o(div), .cmd_o(cmd), .cmd_start_o(cmd_start),
    .tx_word_o(tx_word), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_word_i(rx_word), .rx_valid_i(rx_valid), .xfer_done_i(xfer_done),
    .tx_uflow_i(tx_uflow), .irq_o(irq)
  );

  // {is_read, addr, wdata, expected}
  localparam int NV = 15;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h12345678, 32'h0},
    {1'b1, 8'h00, 32'h0,        32'h12345678},
    {1'b0, 8'h04, 32'hABCD1234, 32'h0},
    {1'b1, 8'h04, 32'h0,        32'h00001234},
    {1'b0, 8'h08, 32'h001F0013, 32'h0},
    {1'b1, 8'h08, 32'h0,        32'h001F0013},
    {1'b0, 8'h10, 32'hFFFFFFFF, 32'h0},
    {1'b1, 8'h10, 32'h0,        32'h0000001F},
    {1'b0, 8'h10, 32'h0,        32'h0},
    {1'b0, 8'h14, 32'h000000A5, 32'h0},
    {1'b1, 8'h14, 32'h0,        32'h000000A5},
    {1'b0, 8'h14, 32'h0,        32'h0},
    {1'b1, 8'h1C, 32'h0,        32'h0},
    {1'b0, 8'h0C, 32'h0000003F, 32'h0},
    {1'b1, 8'h0C, 32'h0,        32'h0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic rx_push(input logic [31:0] w);
    @(negedge clk); rx_valid = 1; rx_word = w;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_take(input string req, input logic [31:0] exp);
    @(negedge clk); #1;
    chk(req, {31'd0, tx_valid}, 32'd1);
    chk(req, tx_word, exp);
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1 cfg", 8'h00, 32'h0);
    rd_chk("R1 div", 8'h04, 32'h4);
    rd_chk("R1 cmd", 8'h08, 32'h0);
    rd_chk("R1 stat", 8'h0C, 32'h0);
    rd_chk("R1 ien", 8'h10, 32'h0);
    rd_chk("R1 thr", 8'h14, 32'h0);
    rd_chk("R1 cnt", 8'h18, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) rd_chk("R2 table", VEC[i][71:64], VEC[i][31:0]);
      else wr(VEC[i][71:64], VEC[i][63:32]);
    end

    // R3 transmit fill with one extra
    for (int i = 0; i < 9; i++) wr(8'h1C, 32'h100 + i);
    rd_chk("R3 tx count full", 8'h18, 32'h80);
    // R10 drain in order
    for (int i = 0; i < 8; i++) tx_take("R10 tx order", 32'h100 + i);
    @(negedge clk); #1;
    chk("R10 tx empty", {31'd0, tx_valid}, 32'd0);
    rd_chk("R8 tx threshold after drain", 8'h0C, 32'h04);
    wr(8'h0C, 32'h3F);

    // R4 receive overrun
    for (int i = 0; i < 9; i++) rx_push(32'h200 + i);
    rd_chk("R4 rx count", 8'h18, 32'h08);
    rd_chk("R4 overflow bit", 8'h0C, 32'h20);
    for (int i = 0; i < 8; i++) rd_chk("R5 rx order", 8'h20, 32'h200 + i);
    rd_chk("R5 empty read", 8'h20, 32'h0);
    rd_chk("R5 count after empty read", 8'h18, 32'h0);

    // R7 write-zero keeps, write-one clears
    wr(8'h0C, 32'h0);
    rd_chk("R7 zero write", 8'h0C, 32'h20);
    wr(8'h0C, 32'h20);
    rd_chk("R7 one write", 8'h0C, 32'h0);

    // R6 pending and done
    wr(8'h08, 32'h7);
    rd_chk("R6 pending set", 8'h0C, 32'h01);
    pulse_done();
    rd_chk("R6 done clears pending", 8'h0C, 32'h02);
    // R7 set wins over clear
    @(negedge clk); bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h02; xfer_done = 1;
    @(negedge clk); bus_wr = 0; xfer_done = 0;
    rd_chk("R7 set wins", 8'h0C, 32'h02);

    // R9 interrupt mapping
    #1 chk("R9 masked", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h01);
    #1 chk("R9 done enabled", {31'd0, irq}, 32'd1);
    wr(8'h10, 32'h1E);
    #1 chk("R9 done disabled", {31'd0, irq}, 32'd0);
    @(negedge clk); tx_uflow = 1;
    @(negedge clk); tx_uflow = 0;
    #1 chk("R9 underflow irq", {31'd0, irq}, 32'd1);
    rd_chk("R6 underflow bit", 8'h0C, 32'h12);
    wr(8'h0C, 32'h3F);
    #1 chk("R9 cleared", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h0);

    // R8 receive level 3
    wr(8'h14, 32'h03);
    wr(8'h0C, 32'h3F);
    rx_push(32'hA0); rx_push(32'hA1);
    rd_chk("R8 rx below level", 8'h0C, 32'h0);
    rx_push(32'hA2);
    rd_chk("R8 rx at level", 8'h0C, 32'h08);
    for (int i = 0; i < 3; i++) rd_chk("R5 rx drain", 8'h20, 32'hA0 + i);
    // R8 transmit level 2
    wr(8'h14, 32'h20);
    wr(8'h0C, 32'h3F);
    for (int i = 0; i < 4; i++) wr(8'h1C, 32'hB0 + i);
    tx_take("R10 tx head", 32'hB0);
    rd_chk("R8 tx above level", 8'h0C, 32'h0);
    tx_take("R10 tx head", 32'hB1);
    rd_chk("R8 tx at level", 8'h0C, 32'h04);

    finished = 1;
    finish_run();
  end
endmodule